// File: doc/BRIEF.md
# Radix-4 Booth Multiplier with Carry-Select Summation

This block multiplies two signed 8-bit two's-complement numbers and returns the exact 16-bit signed product. The multiplier operand is recoded into four radix-4 signed digits. Each digit picks one of five multiples of the multiplicand: zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. The four resulting partial products are weighted by 2, 4 and 6 bit positions and then summed.

Every summation step is a carry-select adder. Each adder is cut into 4-bit sections. Each section has two ripple-carry adders, one that assumes an incoming carry of 0 and one that assumes 1. A multiplexer chooses between the two results as soon as the real carry arrives from the section below.

The block is a two-stage pipeline and accepts one operand pair per clock. A pair is captured on a clock edge where the input strobe is high. Its product is registered on the next edge, and the output flag is high for exactly that one cycle. Between results, the output keeps the last product.

Top module: `booth_csel_mul`

## Requirements
- R1: When `inValid` is high at a rising edge, `outValid` is high during the cycle that follows the second rising edge after it, and `product` holds that pair's result during that cycle.
- R2: `outValid` is high only in the cycle that follows the second edge after an accepted pair, and it pulses exactly once per accepted pair, including when pairs arrive on back-to-back cycles.
- R3: `product` equals the signed product of `opA` and `opB`, both read as 8-bit two's complement. The result is written as 16-bit two's complement and is exact for all 65,536 operand pairs.
- R4: The multiplier `opB` is read in overlapping groups {b[2i+1], b[2i], b[2i-1]} with b[-1] = 0. Group 000 or 111 gives digit 0, 001 or 010 gives +1, 011 gives +2, 100 gives -2, and 101 or 110 gives -1. Digit i carries weight 4^i. A value of `opB` that uses each group code gives the exact product.
- R5: -128 × -128 gives 16384 (0x4000) with no overflow in the doubled multiple.
- R6: -128 × 127 gives -16256 (0xC080), and 127 × -128 gives the same value.
- R7: If either operand is zero, the product is zero.
- R8: In cycles where `outValid` is low, `product` keeps its previous value. Operand values presented while `inValid` is low have no effect on `product` or `outValid`.
- R9: While `rstN` is low, `outValid` is 0 and `product` is 0. Any strobe presented during reset is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Strobe: capture `opA`/`opB` at this edge |
| opA | input | 8 | Multiplicand, two's complement |
| opB | input | 8 | Multiplier, two's complement, Booth-recoded |
| outValid | output | 1 | One-cycle flag marking a new product |
| product | output | 16 | Signed product, held between results |

## Verification
A wrong Booth digit, a wrong negation correction or a wrong carry-select choice changes `product` in the cycle that follows the second edge after the faulty pair. The fault then persists in the held value, so every result flag is compared against an exact signed product in that same cycle. A wrong pipeline-control state shows up one or two edges after the stimulus in a different way. It appears as a missing, doubled or misplaced `outValid` pulse, or as `product` changing while the flag is low. The exhaustive sweep drives pairs on every cycle, so each recoding group and each section carry is exercised.

// File: rtl/bmul_pkg.sv
package bmul_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capEn;   // load operand registers
    logic prodEn;  // load product register
  } mulStrobe_t;

  // One radix-4 signed digit: magnitude select, doubling, sign
  typedef struct packed {
    logic sel;
    logic dbl;
    logic neg;
  } boothDigit_t;

  function automatic boothDigit_t recodeGroup(input logic [2:0] grp);
    boothDigit_t d;
    unique case (grp)
      3'b001, 3'b010: d = '{sel: 1'b1, dbl: 1'b0, neg: 1'b0};
      3'b011:         d = '{sel: 1'b1, dbl: 1'b1, neg: 1'b0};
      3'b100:         d = '{sel: 1'b1, dbl: 1'b1, neg: 1'b1};
      3'b101, 3'b110: d = '{sel: 1'b1, dbl: 1'b0, neg: 1'b1};
      default:        d = '{sel: 1'b0, dbl: 1'b0, neg: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/ripple_sec.sv
module ripple_sec #(
  parameter int SECT = 4
) (
  input  logic [SECT-1:0] a,
  input  logic [SECT-1:0] b,
  input  logic            cin,
  output logic [SECT-1:0] sum,
  output logic            cout
);
  logic chain [SECT+1];

  assign chain[0] = cin;

  for (genvar i = 0; i < SECT; i++) begin : g_bit
    assign sum[i]        = a[i] ^ b[i] ^ chain[i];
    assign chain[i + 1]  = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
  end

  assign cout = chain[SECT];
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int WIDTH = 16,
  parameter int SECT  = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum
);
  localparam int NSEC = WIDTH / SECT;

  logic carry [NSEC+1];
  logic unusedCarryOut;

  assign carry[0] = cin;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic [SECT-1:0] sumLo, sumHi;
    logic            coLo, coHi;

    ripple_sec #(.SECT(SECT)) u_lo (
      .a(a[s*SECT +: SECT]), .b(b[s*SECT +: SECT]), .cin(1'b0),
      .sum(sumLo), .cout(coLo)
    );
    ripple_sec #(.SECT(SECT)) u_hi (
      .a(a[s*SECT +: SECT]), .b(b[s*SECT +: SECT]), .cin(1'b1),
      .sum(sumHi), .cout(coHi)
    );

    assign sum[s*SECT +: SECT] = carry[s] ? sumHi : sumLo;
    assign carry[s + 1]        = carry[s] ? coHi  : coLo;
  end

  // carry beyond the product width is discarded by design
  assign unusedCarryOut = carry[NSEC];
endmodule

// File: rtl/booth_pp.sv
module booth_pp
  import bmul_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SHIFT = 0,
  parameter int PW    = 16
) (
  input  logic [WIDTH-1:0] mcand,
  input  logic [2:0]       grp,
  output logic [PW-1:0]    pp,
  output logic             negBit
);
  localparam int MW = WIDTH + 1;

  boothDigit_t     digit;
  logic [MW-1:0]   single, twice, mag, signedMag;
  logic [PW-1:0]   extended;

  assign digit     = recodeGroup(grp);
  assign single    = {mcand[WIDTH-1], mcand};
  assign twice     = {mcand, 1'b0};
  assign mag       = digit.sel ? (digit.dbl ? twice : single) : '0;
  assign signedMag = digit.neg ? ~mag : mag;
  assign extended  = {{(PW-MW){signedMag[MW-1]}}, signedMag};
  assign pp        = extended << SHIFT;
  assign negBit    = digit.neg;
endmodule

// File: rtl/bmul_datapath.sv
module bmul_datapath
  import bmul_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SECT  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulStrobe_t         strobe,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW  = 2 * WIDTH;
  localparam int NPP = WIDTH / 2;

  logic [WIDTH-1:0] regA, regB;
  logic [WIDTH:0]   bExt;
  logic [NPP-1:0]   negBits;
  logic [PW-1:0]    corr;
  logic [PW-1:0]    pp  [NPP];
  logic [PW-1:0]    acc [NPP+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
    end else if (strobe.capEn) begin
      regA <= opA;
      regB <= opB;
    end
  end

  assign bExt = {regB, 1'b0};

  // +1 of each negated digit placed at that digit's LSB weight
  always_comb begin
    corr = '0;
    for (int i = 0; i < NPP; i++) corr[2*i] = negBits[i];
  end

  assign acc[0] = corr;

  for (genvar g = 0; g < NPP; g++) begin : g_pp
    booth_pp #(.WIDTH(WIDTH), .SHIFT(2*g), .PW(PW)) u_pp (
      .mcand(regA), .grp(bExt[2*g +: 3]), .pp(pp[g]), .negBit(negBits[g])
    );
    csel_adder #(.WIDTH(PW), .SECT(SECT)) u_add (
      .a(acc[g]), .b(pp[g]), .cin(1'b0), .sum(acc[g+1])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              product <= '0;
    else if (strobe.prodEn) product <= acc[NPP];
  end
endmodule

// File: rtl/bmul_ctrl.sv
module bmul_ctrl
  import bmul_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output mulStrobe_t strobe,
  output logic       outValid
);
  logic pending, validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      pending <= inValid;
      validQ  <= pending;
    end
  end

  assign strobe.capEn  = inValid;
  assign strobe.prodEn = pending;
  assign outValid      = validQ;
endmodule

// File: rtl/booth_csel_mul.sv
module booth_csel_mul
  import bmul_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SECT  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic               outValid,
  output logic [2*WIDTH-1:0] product
);
  mulStrobe_t strobe;

  bmul_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  bmul_datapath #(.WIDTH(WIDTH), .SECT(SECT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opA(opA), .opB(opB), .product(product)
  );
endmodule

// File: rtl/bmul_checker.sv
module bmul_checker #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [WIDTH-1:0]   opA,
  input logic [WIDTH-1:0]   opB,
  input logic               outValid,
  input logic [2*WIDTH-1:0] product
);
  logic signed [2*WIDTH-1:0] refProd;
  assign refProd = $signed(opA) * $signed(opB);

  AST_RESULT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);                                  // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);                                // R2
  AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 (product == $past(refProd, 2)));           // R3
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opA == '0 || opB == '0)) |-> ##2 (product == '0)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(product));                            // R8
endmodule

bind booth_csel_mul bmul_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
  .outValid(outValid), .product(product)
);

// File: tb/test_booth_csel_mul.sv
module test_booth_csel_mul;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [7:0]  opA, opB;
  logic        outValid;
  logic [15:0] product;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  booth_csel_mul i_booth_csel_mul (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .product(product)
  );

  // behavioural reference: two-stage delay of flag, value and tag
  string curTag = "R3";
  logic  v1, v2;
  int    p1, p2;
  string t1, t2;
  logic [15:0] lastProd = '0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= inValid;
      p1 <= $signed(opA) * $signed(opB);
      t1 <= curTag;
      v2 <= v1;
      p2 <= p1;
      t2 <= t1;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [15:0] expBits;
      expBits = p2[15:0];
      tests++;
      if (outValid !== v2) begin
        fails++;
        $display("FAIL R2 outValid actual %0b expected %0b", outValid, v2);
      end
      if (v2) begin
        tests++;
        if (product !== expBits) begin
          fails++;
          $display("FAIL %s R1 product actual %0d expected %0d", t2,
                   $signed(product), $signed(expBits));
        end
        lastProd = expBits;
      end else begin
        tests++;
        if (product !== lastProd) begin
          fails++;
          $display("FAIL R8 held product actual %0h expected %0h", product, lastProd);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      finished = 1;
      fails++;
      tests++;
      $display("FAIL R1 watchdog cycles actual %0d expected below 200000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic drive(input int a, input int b, input string tag);
    @(negedge clk);
    inValid = 1'b1;
    opA     = a[7:0];
    opB     = b[7:0];
    curTag  = tag;
  endtask

  task automatic idle(input int a, input int b);
    @(negedge clk);
    inValid = 1'b0;
    opA     = a[7:0];
    opB     = b[7:0];
  endtask

  initial begin
    rstN    = 1'b0;
    inValid = 1'b1;   // strobe during reset must be discarded (R9)
    opA     = 8'd5;
    opB     = 8'd7;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      tests++;
      if (outValid !== 1'b0 || product !== 16'h0) begin
        fails++;
        $display("FAIL R9 reset outputs actual %0b/%0h expected 0/0", outValid, product);
      end
    end
    rstN    = 1'b1;
    inValid = 1'b0;

    // R5, R6 corner values
    drive(-128, -128, "R5");
    idle(0, 0);
    drive(-128, 127, "R6");
    drive(127, -128, "R6");
    // R7 zero operand
    drive(0, -77, "R7");
    drive(93, 0, "R7");
    idle(0, 0);
    // R4: opB low group codes 000,010,100,110 and upper groups 111/011/101
    drive(-93, 0, "R4");
    drive(-93, 1, "R4");
    drive(-93, 2, "R4");
    drive(-93, 3, "R4");
    drive(-93, -1, "R4");
    drive(-93, 8'sh5A, "R4");
    drive(-93, 8'sh2C, "R4");
    drive(-93, -106, "R4");
    // R8: junk operands with strobe low must not disturb the output
    idle(55, -3);
    idle(-100, 44);
    idle(17, 17);
    drive(12, -11, "R8");
    idle(-1, -1);
    idle(-128, -128);
    idle(3, 3);
    // R3 exhaustive, back to back (R2 single pulse per pair)
    for (int a = -128; a < 128; a++) begin
      for (int b = -128; b < 128; b++) begin
        drive(a, b, "R3");
      end
    end
    for (int i = 0; i < 4; i++) idle(0, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule